// File: doc/BRIEF.md
# Bit-Addressable Bidirectional I/O Port

This block is an 8-bit general-purpose I/O port that sits on a processor's internal bus. Each pin has three bits of state: a data latch, a direction bit and an alternate-function enable. Each pin can drive its latch value onto the pad, float so it can be sampled as an input, or hand the pad to a peripheral signal pair. Pin levels pass through a multi-flop synchroniser before they reach the bus.

Software reads and writes whole bytes. It can also set or clear one bit at a time. A single-bit operation works on the whole byte: the port reads the byte through its normal read path, replaces the addressed bit, and writes all eight bits back. As a result, the latches of input-mode and alternate-function pins pick up the synchronised pad level whenever any bit of the data register is changed this way.

Top module: `gpio_rmw_port`

## Requirements
- R1: After reset every pin is an input with its driver off (`pin_oe` all zero), the data latch holds 0, and both the direction register and the alternate-function register read back 0.
- R2: A pin whose direction bit is 1 and whose alternate bit is 0 has `pin_oe` high, shows its latch value on `pin_out`, and returns its latch value on a data-register read.
- R3: A pin whose direction bit and alternate bit are both 0 has `pin_oe` low, and a data-register read returns its synchronised pad level.
- R4: A byte write with `bus_sel`=0 (data register) loads all eight latch bits from `bus_wdata` on the next clock edge, whatever the direction of each bit.
- R5: A latch value keeps its state until a byte write or a bit operation targets the data register. When the direction bit of a pin changes from 0 to 1, the stored latch value appears on `pin_out` with `pin_oe` high in the very cycle after the direction write.
- R6: A bit operation with `bus_sel`=0 loads the latch with the current data-register read value, with bit `bit_idx` replaced by `bit_val`. Input-mode and alternate-function bits therefore take their synchronised pad levels.
- R7: A bit operation with `bus_sel`=1 (direction) or `bus_sel`=2 (alternate enable) changes only bit `bit_idx` of that register, to `bit_val`.
- R8: A pin whose alternate bit is 1 drives `pin_out` from `alt_out` and `pin_oe` from `alt_oe`, and a data-register read returns its synchronised pad level.
- R9: A change on `pin_in` reaches the data-register read path after exactly two rising clock edges.
- R10: When `bit_op` and `bus_wr` are both high in the same cycle, the bit operation takes effect and the byte write is discarded.
- R11: `bus_sel`=3 selects no register: writes and bit operations with it change nothing, and reads with it return 0.
- R12: `bus_rdata` is 0 while `bus_rd` is low. While `bus_rd` is high it shows the selected register in the same cycle; the direction and alternate registers read back their stored bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 2 | Register select: 0 data, 1 direction, 2 alternate enable, 3 none |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Byte write data |
| bus_rdata | output | 8 | Read data |
| bit_op | input | 1 | Single-bit read-modify-write strobe |
| bit_idx | input | 3 | Bit addressed by the bit operation |
| bit_val | input | 1 | Value written to the addressed bit (1 set, 0 clear) |
| pin_in | input | 8 | Pad levels (asynchronous) |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables (1 drives, 0 high impedance) |
| alt_out | input | 8 | Alternate-function output values |
| alt_oe | input | 8 | Alternate-function output enables |

## Verification
The hardest state to reach is a bit operation on a byte whose pins are in all three modes at once, while the pad levels differ from the latch contents. Only then does the overwriting of input and alternate latches show. Once those bits switch back to output, it becomes visible on `pin_out`. The stimulus first loads the latch, then applies pad patterns that are the opposite of it and mixes the direction and alternate settings. It then issues bit operations, sometimes together with a byte write in the same cycle, and turns the pins to outputs to expose the latch. A long random phase follows, in which a behavioural model is compared with the port on every clock.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_DIR  = 2'd1,
      SEL_ALT  = 2'd2,
      SEL_NONE = 2'd3
   } gpio_sel_e;

   // Replace the bits under mask with the requested value.
   function automatic logic [7:0] put_bit8(input logic [7:0] base,
                                           input logic [7:0] mask,
                                           input logic       val);
      return (base & ~mask) | (val ? mask : 8'h00);
   endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pad_i,
   output logic [WIDTH-1:0] pad_sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_pin_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_pin_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= pad_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign pad_sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] latch_i,
   input  logic [WIDTH-1:0] dir_i,
   input  logic [WIDTH-1:0] alt_en_i,
   input  logic [WIDTH-1:0] alt_out_i,
   input  logic [WIDTH-1:0] alt_oe_i,
   input  logic [WIDTH-1:0] pad_sync_i,
   output logic [WIDTH-1:0] pad_out_o,
   output logic [WIDTH-1:0] pad_oe_o,
   output logic [WIDTH-1:0] view_o
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic drive_latch;
      assign drive_latch  = dir_i[i] & ~alt_en_i[i];
      assign pad_out_o[i] = alt_en_i[i] ? alt_out_i[i] : latch_i[i];
      assign pad_oe_o[i]  = alt_en_i[i] ? alt_oe_i[i]  : dir_i[i];
      assign view_o[i]    = drive_latch ? latch_i[i]   : pad_sync_i[i];

      AST_INPUT_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
         (!dir_i[i] && !alt_en_i[i]) |-> (!pad_oe_o[i] && view_o[i] == pad_sync_i[i])) // R3
         else $error("input pin driven or wrong view");
      AST_ALT_OWNS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
         alt_en_i[i] |-> (pad_oe_o[i] == alt_oe_i[i] && view_o[i] == pad_sync_i[i])) // R8
         else $error("alternate pin not routed");
   end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int WIDTH = 8,
   localparam int IDX_W = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  gpio_sel_e        sel_i,
   input  logic             wr_i,
   input  logic [WIDTH-1:0] wdata_i,
   input  logic             bop_i,
   input  logic [IDX_W-1:0] bidx_i,
   input  logic             bval_i,
   input  logic [WIDTH-1:0] view_i,
   output logic [WIDTH-1:0] latch_o,
   output logic [WIDTH-1:0] dir_o,
   output logic [WIDTH-1:0] alt_en_o
);

   if (WIDTH != 8) begin : g_bad_width
      $error("gpio_port_regs: byte-wide port only (WIDTH = 8)");
   end

   logic [WIDTH-1:0] latch_q, dir_q, alt_q;
   logic [WIDTH-1:0] latch_d, dir_d, alt_d;
   logic [WIDTH-1:0] bmask;

   for (genvar i = 0; i < WIDTH; i++) begin : g_mask
      assign bmask[i] = (bidx_i == IDX_W'(i));
   end

   always_comb begin
      latch_d = latch_q;
      dir_d   = dir_q;
      alt_d   = alt_q;
      if (bop_i) begin
         unique case (sel_i)
            SEL_DATA: latch_d = put_bit8(view_i, bmask, bval_i);
            SEL_DIR:  dir_d   = put_bit8(dir_q,  bmask, bval_i);
            SEL_ALT:  alt_d   = put_bit8(alt_q,  bmask, bval_i);
            default:  ;
         endcase
      end else if (wr_i) begin
         unique case (sel_i)
            SEL_DATA: latch_d = wdata_i;
            SEL_DIR:  dir_d   = wdata_i;
            SEL_ALT:  alt_d   = wdata_i;
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '0;
         alt_q   <= '0;
      end else begin
         latch_q <= latch_d;
         dir_q   <= dir_d;
         alt_q   <= alt_d;
      end
   end

   assign latch_o  = latch_q;
   assign dir_o    = dir_q;
   assign alt_en_o = alt_q;

   AST_BYTE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !bop_i && sel_i == SEL_DATA) |=> latch_q == $past(wdata_i)) // R4
      else $error("byte write lost");
   AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !((wr_i || bop_i) && sel_i == SEL_DATA) |=> $stable(latch_q)) // R5
      else $error("latch changed without access");
   AST_RMW_TARGET_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      (bop_i && sel_i == SEL_DATA) |=> latch_q[$past(bidx_i)] == $past(bval_i)) // R6
      else $error("addressed bit wrong");
   AST_BITOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (bop_i && wr_i && sel_i == SEL_DIR) |=> $countones(dir_q ^ $past(dir_q)) <= 1) // R10
      else $error("byte write not suppressed");
   AST_NONE_SEL_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_i || bop_i) && sel_i == SEL_NONE) |=> ($stable(dir_q) && $stable(alt_q))) // R11
      else $error("unmapped select modified state");

endmodule

// File: rtl/gpio_rmw_port.sv
module gpio_rmw_port
   import gpio_port_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W      = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       bus_sel,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [WIDTH-1:0] bus_wdata,
   output logic [WIDTH-1:0] bus_rdata,
   input  logic             bit_op,
   input  logic [IDX_W-1:0] bit_idx,
   input  logic             bit_val,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_oe,
   input  logic [WIDTH-1:0] alt_out,
   input  logic [WIDTH-1:0] alt_oe
);

   gpio_sel_e        sel;
   logic [WIDTH-1:0] pad_sync, view, latch_q, dir_q, alt_q;

   assign sel = gpio_sel_e'(bus_sel);

   gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .pad_i(pin_in), .pad_sync_o(pad_sync)
   );

   gpio_port_regs #(.WIDTH(WIDTH)) i_regs (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .wr_i(bus_wr), .wdata_i(bus_wdata),
      .bop_i(bit_op), .bidx_i(bit_idx), .bval_i(bit_val), .view_i(view),
      .latch_o(latch_q), .dir_o(dir_q), .alt_en_o(alt_q)
   );

   gpio_pad_mux #(.WIDTH(WIDTH)) i_mux (
      .clk(clk), .rst_n(rst_n), .latch_i(latch_q), .dir_i(dir_q), .alt_en_i(alt_q),
      .alt_out_i(alt_out), .alt_oe_i(alt_oe), .pad_sync_i(pad_sync),
      .pad_out_o(pin_out), .pad_oe_o(pin_oe), .view_o(view)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         unique case (sel)
            SEL_DATA: bus_rdata = view;
            SEL_DIR:  bus_rdata = dir_q;
            SEL_ALT:  bus_rdata = alt_q;
            default:  bus_rdata = '0;
         endcase
      end
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_chk
      AST_DIR_RISE_SHOWS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(dir_q[i]) && !alt_q[i]) |-> (pin_oe[i] && pin_out[i] == latch_q[i])) // R5
         else $error("latch not exposed on direction change");
      AST_OUTPUT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
         (dir_q[i] && !alt_q[i] && bus_rd && sel == SEL_DATA) |-> bus_rdata[i] == pin_out[i]) // R2
         else $error("output bit read mismatch");
   end

   AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> bus_rdata == '0) // R12
      else $error("read data without strobe");

endmodule

// File: tb/test_gpio_rmw_port.sv
module test_gpio_rmw_port;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_sel = 2'd0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0, bit_op = 1'b0, bit_val = 1'b0;
   logic [7:0] bus_wdata = 8'h00, pin_in = 8'h00, alt_out = 8'h00, alt_oe = 8'h00;
   logic [2:0] bit_idx = 3'd0;
   logic [7:0] bus_rdata, pin_out, pin_oe;

   int total = 0, failed = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   gpio_rmw_port i_gpio_rmw_port (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bit_op(bit_op), .bit_idx(bit_idx),
      .bit_val(bit_val), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .alt_out(alt_out), .alt_oe(alt_oe)
   );

   // ---------------- behavioural reference ----------------
   logic [7:0] m_lat = 0, m_dir = 0, m_alt = 0;
   logic [7:0] m_pipe [$];

   function automatic logic [7:0] m_seen();
      return m_pipe[1];
   endfunction

   function automatic logic [7:0] m_view();
      logic [7:0] v;
      for (int b = 0; b < 8; b++)
         v[b] = (m_dir[b] && !m_alt[b]) ? m_lat[b] : m_seen()[b];
      return v;
   endfunction

   initial begin
      m_pipe.push_back(8'h00);
      m_pipe.push_back(8'h00);
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_lat = 0; m_dir = 0; m_alt = 0;
         m_pipe[0] = 0; m_pipe[1] = 0;
      end else begin
         logic [7:0] v;
         v = m_view();
         if (bit_op) begin
            case (bus_sel)
               2'd0: begin m_lat = v;     m_lat[bit_idx] = bit_val; end
               2'd1: m_dir[bit_idx] = bit_val;
               2'd2: m_alt[bit_idx] = bit_val;
               default: ;
            endcase
         end else if (bus_wr) begin
            case (bus_sel)
               2'd0: m_lat = bus_wdata;
               2'd1: m_dir = bus_wdata;
               2'd2: m_alt = bus_wdata;
               default: ;
            endcase
         end
         void'(m_pipe.pop_back());
         m_pipe.push_front(pin_in);
      end
   end

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      total++;
      if (got !== exp) begin
         failed++;
         $display("FAIL %s got %02h expected %02h at %0t", req, got, exp, $time);
      end
   endtask

   // every clock: compare all outputs with the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [7:0] eo, ee, er;
         for (int b = 0; b < 8; b++) begin
            eo[b] = m_alt[b] ? alt_out[b] : m_lat[b];
            ee[b] = m_alt[b] ? alt_oe[b]  : m_dir[b];
         end
         if (!bus_rd) er = 0;
         else case (bus_sel)
            2'd0: er = m_view();
            2'd1: er = m_dir;
            2'd2: er = m_alt;
            default: er = 0;
         endcase
         check("R2 pin_out model", pin_out, eo);
         check("R8 pin_oe model", pin_oe, ee);
         check("R12 rdata model", bus_rdata, er);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic quiet();
      bus_wr = 0; bus_rd = 0; bit_op = 0;
   endtask

   task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
      @(posedge clk); #1;
      bus_sel = s; bus_wdata = d; bus_wr = 1;
      @(posedge clk); #1;
      quiet();
   endtask

   task automatic bop(input logic [1:0] s, input logic [2:0] idx, input logic v,
                      input logic with_wr, input logic [7:0] d);
      @(posedge clk); #1;
      bus_sel = s; bit_idx = idx; bit_val = v; bit_op = 1;
      bus_wr = with_wr; bus_wdata = d;
      @(posedge clk); #1;
      quiet();
   endtask

   task automatic rd_reg(input logic [1:0] s, output logic [7:0] v);
      bus_sel = s; bus_rd = 1; #1;
      v = bus_rdata;
      bus_rd = 0;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; failed++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", total - failed, total);
         $finish;
      end
   end

   // ---------------- directed and random sequence ----------------
   initial begin
      logic [7:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      check("R1 oe after reset", pin_oe, 8'h00);
      rd_reg(2'd1, v); check("R1 dir after reset", v, 8'h00);
      rd_reg(2'd2, v); check("R1 alt after reset", v, 8'h00);
      rd_reg(2'd0, v); check("R1 input read after reset", v, 8'h00);

      // R4: write latch while all inputs, then R5 expose
      wr_reg(2'd0, 8'hA5);
      check("R4 input latch not driven", pin_oe, 8'h00);
      wr_reg(2'd1, 8'hFF);
      check("R5 latch appears at once", pin_out, 8'hA5);
      check("R2 outputs enabled", pin_oe, 8'hFF);
      rd_reg(2'd0, v); check("R2 read returns latch", v, 8'hA5);

      // R3: mixed directions
      pin_in = 8'h3C;
      wr_reg(2'd1, 8'h0F);
      repeat (2) @(posedge clk); #1;
      rd_reg(2'd0, v); check("R3 input bits read pad", v, 8'h35);
      check("R3 input bits float", pin_oe, 8'h0F);

      // R6: bit set rewrites byte from read view
      bop(2'd0, 3'd1, 1'b1, 1'b0, 8'h00);
      wr_reg(2'd1, 8'hFF);
      check("R6 rmw latch content", pin_out, 8'h37);
      wr_reg(2'd1, 8'h0F);

      // R9: two-edge synchroniser
      pin_in = 8'hC0;
      @(posedge clk); #1;
      rd_reg(2'd0, v); check("R9 one edge still old", v, 8'h37);
      @(posedge clk); #1;
      rd_reg(2'd0, v); check("R9 two edges new", v, 8'hC7);

      // R8: alternate function on bit 7
      alt_out = 8'h80; alt_oe = 8'h80;
      wr_reg(2'd2, 8'h80);
      check("R8 alt oe", pin_oe, 8'h8F);
      check("R8 alt out", pin_out & 8'h80, 8'h80);
      rd_reg(2'd0, v); check("R8 alt bit reads pad", v, 8'hC7);

      // R7: clear direction bit 0 only
      bop(2'd1, 3'd0, 1'b0, 1'b0, 8'h00);
      rd_reg(2'd1, v); check("R7 dir bit clear", v, 8'h0E);
      rd_reg(2'd2, v); check("R7 alt untouched", v, 8'h80);

      // R10: bit op wins over byte write; view = C6, clear bit 7
      bop(2'd0, 3'd7, 1'b0, 1'b1, 8'h00);
      wr_reg(2'd2, 8'h00);
      wr_reg(2'd1, 8'hFF);
      check("R10 bit op beats byte write", pin_out, 8'h46);

      // R11: unmapped select
      wr_reg(2'd3, 8'h00);
      bop(2'd3, 3'd2, 1'b0, 1'b0, 8'h00);
      check("R11 state unchanged", pin_out, 8'h46);
      check("R11 oe unchanged", pin_oe, 8'hFF);
      rd_reg(2'd3, v); check("R11 read zero", v, 8'h00);
      check("R12 idle rdata", bus_rdata, 8'h00);

      // random phase, model compared every clock
      for (int n = 0; n < 4000; n++) begin
         @(posedge clk); #1;
         bus_sel   = 2'($urandom_range(0, 3));
         bus_wr    = ($urandom_range(0, 9) < 3);
         bit_op    = ($urandom_range(0, 9) < 2);
         bus_rd    = ($urandom_range(0, 1) == 1);
         bus_wdata = 8'($urandom);
         bit_idx   = 3'($urandom);
         bit_val   = 1'($urandom);
         alt_out   = 8'($urandom);
         alt_oe    = 8'($urandom);
         if ($urandom_range(0, 3) == 0) pin_in = 8'($urandom);
      end
      @(posedge clk); #1;
      quiet();
      @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

endmodule